// File: doc/BRIEF.md
# I2C Repeated-START Sequencer with Arbitration Watch

This block is the part of an I2C controller that produces a repeated START on an open-drain bus. It starts with SCL held low after a previous transfer. It lets SDA go high, releases SCL, and then pulls SDA low while SCL is high. It finishes by pulling SCL low again. A programmable reload value sets the length of each timed phase through an internal down-counter.

Another controller can drive the same bus. At two points the block compares the line levels with what it expects, and it reports a lost arbitration on a sticky collision flag:
- if SDA is already low when SCL first reads high, or
- if SCL drops while the block still has SDA released.

After a collision the block lets go of both lines and goes idle. After a clean sequence it raises a sticky done flag and keeps both lines held low until the next request. Both flags stay set until the clear input is pulsed.

Top module: `i2c_rs_gen`

## Requirements
- R1: After reset, both open-drain enables are 0 (lines released), and done and collision are 0.
- R2: An accepted request pulls SCL low and releases SDA for exactly n cycles, with n = max(reload, 1). SCL is then released.
- R3: Both line inputs pass through a two-flop synchronizer. After releasing SCL, the block waits as long as the synchronized SCL stays low. A target that stretches SCL therefore only delays the sequence.
- R4: If synchronized SDA is 0 in the cycle where synchronized SCL is first seen high, collision is set. In that same cycle both enables drop to 0 and the block goes idle.
- R5: If SDA is high at that point, a second n-cycle count starts with both lines released. SDA going low during this count is not a collision.
- R6: If synchronized SCL reads 0 during the second count, collision is set and both lines are released in the same cycle.
- R7: At the end of the second count, SDA is pulled low (sda_oe=1, scl_oe=0) for a third n-cycle count. The block then pulls SCL low and sets done. For a bus that does not interfere, done rises 3n+3 clock edges after the edge that accepts the request. Both enables stay 1 until the next request.
- R8: A reload value of 0 behaves exactly like a reload value of 1.
- R9: A request that arrives while a sequence is running is ignored and produces no second done.
- R10: done and collision are sticky until clr_flags is pulsed. clr_flags clears both at the next edge and wins over a same-cycle set.
- R11: A request is accepted both from idle and from the held state left by a completed sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Request a repeated START |
| clr_flags | input | 1 | Clear the done and collision flags |
| reload | input | CNT_W | Reload value for the phase down-counter |
| sda_in | input | 1 | Sampled SDA line level |
| scl_in | input | 1 | Sampled SCL line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| scl_oe | output | 1 | 1 pulls SCL low |
| done | output | 1 | Sticky completion flag |
| collision | output | 1 | Sticky lost-arbitration flag |

## Verification
The hardest case to reach is an SCL drop by another controller that lands inside the second count. It has to arrive after the block has released SCL and seen it high, but before that count expires. The bench models a wired-AND bus with a second driver. It counts clock edges from the accepted request and times the intruding pull into that window, using a long reload. The same timing model is used for SCL stretching, and for an SDA pull that must not count as a collision.

// File: rtl/i2c_rs_pkg.sv
package i2c_rs_pkg;

    localparam int SYNC_STAGES = 2;

    typedef enum logic [2:0] {
        RS_IDLE  = 3'd0,
        RS_SETUP = 3'd1,
        RS_RISE  = 3'd2,
        RS_HIGH  = 3'd3,
        RS_START = 3'd4,
        RS_HOLD  = 3'd5
    } rs_state_e;

    typedef struct packed {
        logic sda;
        logic scl;
    } line_pair_t;

    function automatic line_pair_t drive_for(rs_state_e st);
        line_pair_t d;
        d = '{sda: 1'b0, scl: 1'b0};
        case (st)
            RS_SETUP: d = '{sda: 1'b0, scl: 1'b1};
            RS_START: d = '{sda: 1'b1, scl: 1'b0};
            RS_HOLD:  d = '{sda: 1'b1, scl: 1'b1};
            default:  d = '{sda: 1'b0, scl: 1'b0};
        endcase
        return d;
    endfunction

    function automatic logic is_counting(rs_state_e st);
        return (st == RS_SETUP) || (st == RS_HIGH) || (st == RS_START);
    endfunction

endpackage

// File: rtl/i2c_rs_sync.sv
module i2c_rs_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    logic [WIDTH-1:0] chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '1;
                    else     chain[s] <= d_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '1;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign d_out = chain[STAGES-1];
endmodule

// File: rtl/i2c_rs_timer.sv
module i2c_rs_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             en,
    input  logic [CNT_W-1:0] reload,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= ONE;
        end else if (load) begin
            cnt_q <= (reload == '0) ? ONE : reload;
        end else if (en && cnt_q > ONE) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign expire = en && (cnt_q == ONE);
endmodule

// File: rtl/i2c_rs_ctrl.sv
module i2c_rs_ctrl
    import i2c_rs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start_req,
    input  logic       clr_flags,
    input  line_pair_t line_s,
    input  logic       expire,
    output logic       load,
    output logic       count_en,
    output line_pair_t drive,
    output logic       done,
    output logic       collision,
    output rs_state_e  state
);
    rs_state_e state_q, state_d;
    logic      done_q, coll_q;
    logic      done_set, coll_set;

    always_comb begin
        state_d  = state_q;
        load     = 1'b0;
        done_set = 1'b0;
        coll_set = 1'b0;
        case (state_q)
            RS_IDLE, RS_HOLD: begin
                if (start_req) begin
                    state_d = RS_SETUP;
                    load    = 1'b1;
                end
            end
            RS_SETUP: begin
                if (expire) state_d = RS_RISE;
            end
            RS_RISE: begin
                if (line_s.scl) begin
                    if (!line_s.sda) begin
                        coll_set = 1'b1;
                        state_d  = RS_IDLE;
                    end else begin
                        state_d = RS_HIGH;
                        load    = 1'b1;
                    end
                end
            end
            RS_HIGH: begin
                if (!line_s.scl) begin
                    coll_set = 1'b1;
                    state_d  = RS_IDLE;
                end else if (expire) begin
                    state_d = RS_START;
                    load    = 1'b1;
                end
            end
            RS_START: begin
                if (expire) begin
                    state_d  = RS_HOLD;
                    done_set = 1'b1;
                end
            end
            default: state_d = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RS_IDLE;
            done_q  <= 1'b0;
            coll_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= clr_flags ? 1'b0 : (done_q | done_set);
            coll_q  <= clr_flags ? 1'b0 : (coll_q | coll_set);
        end
    end

    assign count_en  = is_counting(state_q);
    assign drive     = drive_for(state_q);
    assign done      = done_q;
    assign collision = coll_q;
    assign state     = state_q;
endmodule

// File: rtl/i2c_rs_gen.sv
module i2c_rs_gen
    import i2c_rs_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_req,
    input  logic             clr_flags,
    input  logic [CNT_W-1:0] reload,
    input  logic             sda_in,
    input  logic             scl_in,
    output logic             sda_oe,
    output logic             scl_oe,
    output logic             done,
    output logic             collision
);
    localparam int LINES = $bits(line_pair_t);

    line_pair_t raw_lines, sync_lines, drive;
    logic       load, count_en, expire;
    rs_state_e  fsm_state;

    assign raw_lines = '{sda: sda_in, scl: scl_in};

    i2c_rs_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .d_in (raw_lines),
        .d_out(sync_lines)
    );

    i2c_rs_timer #(.CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .load  (load),
        .en    (count_en),
        .reload(reload),
        .expire(expire)
    );

    i2c_rs_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start_req(start_req),
        .clr_flags(clr_flags),
        .line_s   (sync_lines),
        .expire   (expire),
        .load     (load),
        .count_en (count_en),
        .drive    (drive),
        .done     (done),
        .collision(collision),
        .state    (fsm_state)
    );

    assign sda_oe = drive.sda;
    assign scl_oe = drive.scl;
endmodule

// File: rtl/i2c_rs_checker.sv
module i2c_rs_checker (
    input logic clk,
    input logic rst,
    input logic clr_flags,
    input logic sda_oe,
    input logic scl_oe,
    input logic done,
    input logic collision
);
    assert_coll_release_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(collision) |-> (!sda_oe && !scl_oe));

    assert_done_hold_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> (sda_oe && scl_oe));

    assert_sda_pull_scl_free_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_oe);

    assert_scl_free_sda_free_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(scl_oe) |-> !sda_oe);

    assert_done_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (done && !clr_flags) |=> done);

    assert_coll_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (collision && !clr_flags) |=> collision);

    assert_clear_wins_R10: assert property (@(posedge clk) disable iff (rst)
        clr_flags |=> (!done && !collision));
endmodule

bind i2c_rs_gen i2c_rs_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .clr_flags(clr_flags),
    .sda_oe   (sda_oe),
    .scl_oe   (scl_oe),
    .done     (done),
    .collision(collision)
);

// File: tb/tb_i2c_rs_gen.sv
module tb_i2c_rs_gen;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start_req = 1'b0;
    logic             clr_flags = 1'b0;
    logic [CNT_W-1:0] reload = '0;
    logic             other_sda = 1'b0;
    logic             other_scl = 1'b0;
    logic             sda_oe, scl_oe, done, collision;
    logic             sda_line, scl_line;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    typedef struct {
        int    kind;
        int    ref_c;
        int    delta;
        string req;
    } sb_item_t;

    sb_item_t sb[$];

    always #10 clk = ~clk;

    assign sda_line = ~(sda_oe | other_sda);
    assign scl_line = ~(scl_oe | other_scl);

    i2c_rs_gen #(.CNT_W(CNT_W)) dut (
        .clk      (clk),
        .rst      (rst),
        .start_req(start_req),
        .clr_flags(clr_flags),
        .reload   (reload),
        .sda_in   (sda_line),
        .scl_in   (scl_line),
        .sda_oe   (sda_oe),
        .scl_oe   (scl_oe),
        .done     (done),
        .collision(collision)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    logic done_prev = 1'b0;
    logic coll_prev = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if ((done && !done_prev) || (collision && !coll_prev)) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R9", "unexpected flag event", cyc, -1);
                end else begin
                    sb_item_t it;
                    it = sb.pop_front();
                    check((it.kind == 1) == (collision && !coll_prev), it.req,
                          "event kind", int'(collision), it.kind);
                    check(cyc - it.ref_c == it.delta, it.req, "event latency",
                          cyc - it.ref_c, it.delta);
                end
            end
        end
        done_prev <= done;
        coll_prev <= collision;
    end

    task automatic wait_until(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic push(input int kind, input int ref_c, input int delta, input string req);
        sb_item_t it;
        it.kind = kind; it.ref_c = ref_c; it.delta = delta; it.req = req;
        sb.push_back(it);
    endtask

    task automatic issue(input int rl, output int c);
        @(negedge clk);
        reload    = CNT_W'(rl);
        start_req = 1'b1;
        c         = cyc;
        @(negedge clk);
        start_req = 1'b0;
    endtask

    task automatic clear_flags();
        @(negedge clk);
        clr_flags = 1'b1;
        @(negedge clk);
        clr_flags = 1'b0;
        check(!done && !collision, "R10", "flags after clear",
              int'({done, collision}), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int c, n, p, r;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!sda_oe && !scl_oe, "R1", "enables after reset", int'({sda_oe, scl_oe}), 0);
        check(!done && !collision, "R1", "flags after reset", int'({done, collision}), 0);

        // R2 / R7 / R11: clean sequence from idle, n = 4
        n = 4;
        issue(n, c);
        push(0, c, 3*n + 4, "R7");
        check(!sda_oe && scl_oe, "R2", "setup drive start", int'({sda_oe, scl_oe}), 1);
        wait_until(c + n);
        check(scl_oe == 1'b1, "R2", "scl held last setup cycle", int'(scl_oe), 1);
        wait_until(c + n + 1);
        check(scl_oe == 1'b0, "R2", "scl released after n", int'(scl_oe), 0);
        wait_until(c + 2*n + 5);
        check(sda_oe && !scl_oe, "R7", "start drive", int'({sda_oe, scl_oe}), 2);
        wait_until(c + 3*n + 6);
        check(sda_oe && scl_oe, "R7", "hold after done", int'({sda_oe, scl_oe}), 3);
        repeat (5) @(negedge clk);
        check(done == 1'b1, "R10", "done sticky", int'(done), 1);
        clear_flags();

        // R8 / R11: reload 0 from held state
        issue(0, c);
        push(0, c, 7, "R8");
        wait_until(c + 10);
        check(done == 1'b1, "R11", "done from held state", int'(done), 1);
        clear_flags();

        // R4: other driver holds SDA low
        n = 3;
        other_sda = 1'b1;
        issue(n, c);
        push(1, c, n + 4, "R4");
        wait_until(c + n + 5);
        check(!sda_oe && !scl_oe, "R4", "released after collision", int'({sda_oe, scl_oe}), 0);
        check(done == 1'b0, "R4", "no done after collision", int'(done), 0);
        other_sda = 1'b0;
        repeat (3) @(negedge clk);
        clear_flags();

        // R6: other driver pulls SCL low in second count
        n = 10;
        issue(n, c);
        p = c + n + 6;
        push(1, p, 3, "R6");
        wait_until(p);
        other_scl = 1'b1;
        wait_until(p + 4);
        check(!sda_oe && !scl_oe, "R6", "released after collision", int'({sda_oe, scl_oe}), 0);
        other_scl = 1'b0;
        wait_until(p + 3*n);
        check(done == 1'b0 && collision == 1'b1, "R6", "still idle with collision",
              int'({done, collision}), 1);
        clear_flags();

        // R5: SDA pulled low in second count is not a collision
        n = 6;
        issue(n, c);
        push(0, c, 3*n + 4, "R5");
        wait_until(c + n + 6);
        other_sda = 1'b1;
        wait_until(c + 3*n + 6);
        check(collision == 1'b0, "R5", "no collision on sda fall", int'(collision), 0);
        other_sda = 1'b0;
        clear_flags();

        // R3: SCL stretched by another driver
        n = 5;
        other_scl = 1'b1;
        issue(n, c);
        r = c + n + 8;
        push(0, r, 2*n + 3, "R3");
        wait_until(r);
        check(scl_oe == 1'b0 && done == 1'b0, "R3", "waiting for scl high",
              int'({scl_oe, done}), 0);
        other_scl = 1'b0;
        wait_until(r + 2*n + 5);
        clear_flags();

        // R9: request during a running sequence is ignored
        n = 8;
        issue(n, c);
        push(0, c, 3*n + 4, "R9");
        wait_until(c + 3);
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        wait_until(c + 3*n + 40);
        check(sda_oe && scl_oe, "R9", "still held after ignored request",
              int'({sda_oe, scl_oe}), 3);
        check(sb.size() == 0, "R9", "scoreboard drained", sb.size(), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule